// File: doc/BRIEF.md
# Flash Operation Status Poller

After a host has sent a program or erase command to a flash-like device, this controller decides on its own when that operation has ended and how. A single start pulse gives it the kind of operation, the address to poll and the data that was written. It then reads the device status byte over a simple request/acknowledge read port, one read after another. Toggle-bit polling compares each read with the one before it. Program operations also use data-complement polling. When the device raises its time-limit flag, the toggle bit is read once more before any failure is declared. A write-buffer abort is handled as its own outcome.

The poller reports one of four outcomes: success, device failure, buffer abort (so the host can send the abort-reset sequence) or a host-side timeout. A device failure or an abort is followed by one extra confirming read before the result is given. The result code stays on its output until the next start.

States and transitions:
- ST_IDLE goes to ST_FIRST when start is accepted.
- ST_FIRST goes to ST_POLL when its read completes.
- ST_POLL has four exits: ST_IDLE on completion or on timeout, ST_RECHECK when the time-limit flag is seen, ST_CONFIRM on an abort, and ST_POLL again while the device is still busy.
- ST_RECHECK goes to ST_CONFIRM if the bit still toggles, or to ST_IDLE with success if it does not.
- ST_CONFIRM goes to ST_IDLE with the pending code.

Top module: `fsp_poller`

## Requirements
- R1: After reset, busy, done and rd_req are 0 and result is 0 (no result).
- R2: Every read made for an operation uses the poll_addr captured at its start. The host supplies the last-loaded address for buffer programs and an address inside the target area for erases.
- R3: Toggling means bit 6 differs between two consecutive reads. For erase kinds (op_kind 2 = sector, 3 = chip), a non-toggling read pair completes the operation with result 1 (ok).
- R4: For program kinds (op_kind 0 = word, 1 = buffer), completion also needs bit 7 of the read to equal bit 7 of exp_data. A stable read whose bit 7 is complemented counts as still busy.
- R5: If a toggling read shows bit 5 = 1, one more read is made. If that read still toggles against the flagged read, the result is 2 (device fail). Otherwise it is 1 (ok).
- R6: If a toggling read shows bit 1 = 1 during a buffer program (op_kind 1), the result is 3 (abort). Bit 1 is ignored for all other kinds.
- R7: After a device fail or an abort has been decided, exactly one further confirming read is made before done is raised.
- R8: A toggling or still-busy read pair with no flag counts as one busy verdict. When the count of busy verdicts reaches max_polls, the result is 4 (timeout) and no further read is made. A max_polls of 0 behaves like 1.
- R9: done is a one-cycle pulse that comes with a non-zero result. The result is held after done until the next accepted start, which clears it to 0.
- R10: A start pulse while busy is ignored: the operation, its address and its outcome are unchanged.
- R11: rd_req, once raised, stays high with a stable rd_addr until rd_ack is seen. The read data is taken in the rd_ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| op_kind | input | 2 | 0 word program, 1 buffer program, 2 sector erase, 3 chip erase |
| poll_addr | input | ADDR_W | Address used for all status reads |
| exp_data | input | DATA_W | Data written by the program operation |
| max_polls | input | CNT_W | Busy verdicts allowed before host timeout |
| rd_req | output | 1 | Read request to the device port |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read completion strobe, data valid |
| rd_data | input | DATA_W | Status byte returned by the device |
| busy | output | 1 | Operation being polled |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 none, 1 ok, 2 device fail, 3 abort, 4 timeout |

## Verification
The assertions rely on the read port answering each request with one rd_ack pulse, never an unrequested one. They also rely on start being a single-cycle pulse whose operands are valid in that cycle. The bench's responder raises rd_ack only in the cycle after it sees a pending request and never in two cycles in a row, and the bench drives start for exactly one cycle. The responder's status byte is a function of the read index and a chosen tail pattern, so busy bit patterns, flag timing and the stable end data are fixed for each case.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        OP_PROG_WORD  = 2'd0,
        OP_PROG_BUF   = 2'd1,
        OP_ERASE_SECT = 2'd2,
        OP_ERASE_CHIP = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        RES_NONE     = 3'd0,
        RES_OK       = 3'd1,
        RES_DEV_FAIL = 3'd2,
        RES_ABORT    = 3'd3,
        RES_TIMEOUT  = 3'd4
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_POLL,
        ST_RECHECK,
        ST_CONFIRM
    } state_e;

    typedef enum logic [1:0] {
        V_BUSY,
        V_DONE,
        V_ABORT,
        V_FLAG
    } verdict_e;

    // Status bit positions decoded from the device status byte
    localparam int BIT_DPOLL = 7;
    localparam int BIT_TOG   = 6;
    localparam int BIT_TLIM  = 5;
    localparam int BIT_ABRT  = 1;

endpackage

// File: rtl/fsp_status_eval.sv
module fsp_status_eval
    import fsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] prev,
    input  logic [1:0]        kind,
    input  logic              exp_bit,
    output logic              toggled,
    output verdict_e          verdict
);

    logic is_prog;
    logic is_buf;

    always_comb begin
        is_prog = (kind == OP_PROG_WORD) || (kind == OP_PROG_BUF);
        is_buf  = (kind == OP_PROG_BUF);
        toggled = cur[BIT_TOG] ^ prev[BIT_TOG];
        if (!toggled) begin
            if (is_prog && (cur[BIT_DPOLL] != exp_bit)) begin
                verdict = V_BUSY;
            end else begin
                verdict = V_DONE;
            end
        end else if (is_buf && cur[BIT_ABRT]) begin
            verdict = V_ABORT;
        end else if (cur[BIT_TLIM]) begin
            verdict = V_FLAG;
        end else begin
            verdict = V_BUSY;
        end
    end

endmodule

// File: rtl/fsp_poll_budget.sv
module fsp_poll_budget #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic             exhausted
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [EXT_W-1:0] count_next;

    always_comb begin
        count_next = {1'b0, count_q} + EXT_W'(1);
        exhausted  = (count_next >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (bump) begin
            count_q <= count_next[CNT_W-1:0];
        end
    end

    // R8: the verdict count never passes the budget
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q < limit) || (count_q == '0));

endmodule

// File: rtl/fsp_poller.sv
module fsp_poller
    import fsp_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [2:0]        result
);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        kind_q;
    logic              expbit_q;
    logic [CNT_W-1:0]  limit_q;
    logic [DATA_W-1:0] prev_q;
    result_e           pend_q, pend_d;
    result_e           result_q;
    logic              done_q;

    logic              accept;
    logic              fire;
    logic              fin;
    result_e           fin_code;
    logic              bump;
    logic              exhausted;
    logic              toggled;
    verdict_e          verdict;

    fsp_status_eval #(.DATA_W(DATA_W)) u_eval (
        .cur     (rd_data),
        .prev    (prev_q),
        .kind    (kind_q),
        .exp_bit (expbit_q),
        .toggled (toggled),
        .verdict (verdict)
    );

    fsp_poll_budget #(.CNT_W(CNT_W)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .bump      (bump),
        .limit     (limit_q),
        .exhausted (exhausted)
    );

    always_comb begin
        accept   = (state_q == ST_IDLE) && start;
        fire     = rd_req && rd_ack;
        state_d  = state_q;
        pend_d   = pend_q;
        fin      = 1'b0;
        fin_code = RES_NONE;
        bump     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (fire) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (fire) begin
                    unique case (verdict)
                        V_DONE: begin
                            state_d  = ST_IDLE;
                            fin      = 1'b1;
                            fin_code = RES_OK;
                        end
                        V_ABORT: begin
                            state_d = ST_CONFIRM;
                            pend_d  = RES_ABORT;
                        end
                        V_FLAG: begin
                            state_d = ST_RECHECK;
                        end
                        V_BUSY: begin
                            if (exhausted) begin
                                state_d  = ST_IDLE;
                                fin      = 1'b1;
                                fin_code = RES_TIMEOUT;
                            end else begin
                                bump = 1'b1;
                            end
                        end
                    endcase
                end
            end
            ST_RECHECK: begin
                if (fire) begin
                    if (toggled) begin
                        state_d = ST_CONFIRM;
                        pend_d  = RES_DEV_FAIL;
                    end else begin
                        state_d  = ST_IDLE;
                        fin      = 1'b1;
                        fin_code = RES_OK;
                    end
                end
            end
            ST_CONFIRM: begin
                if (fire) begin
                    state_d  = ST_IDLE;
                    fin      = 1'b1;
                    fin_code = pend_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            kind_q   <= '0;
            expbit_q <= 1'b0;
            limit_q  <= '0;
            prev_q   <= '0;
            pend_q   <= RES_NONE;
            result_q <= RES_NONE;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            done_q  <= fin;
            if (accept) begin
                addr_q   <= poll_addr;
                kind_q   <= op_kind;
                expbit_q <= exp_data[BIT_DPOLL];
                limit_q  <= max_polls;
                result_q <= RES_NONE;
                pend_q   <= RES_NONE;
            end
            if (fire) prev_q <= rd_data;
            if (fin) result_q <= fin_code;
        end
    end

    always_comb begin
        rd_req  = (state_q != ST_IDLE);
        rd_addr = addr_q;
        busy    = (state_q != ST_IDLE);
        done    = done_q;
        result  = result_q;
    end

    // R11: request is held with a stable address until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done always carries an outcome
    assert_done_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 3'd0));

    // R9: outcome held while idle and no start
    assert_result_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R10: a start while busy does not move the poll address
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rd_addr));

endmodule

// File: tb/fsp_poller_test.sv
`timescale 1ns/1ps
module fsp_poller_test;

    localparam int ADDR_W = 22;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam real CLK_P = 20.0;

    localparam logic [2:0] TL_DONE  = 3'd0;
    localparam logic [2:0] TL_HANG  = 3'd1;
    localparam logic [2:0] TL_FAIL  = 3'd2;
    localparam logic [2:0] TL_LATE  = 3'd3;
    localparam logic [2:0] TL_ABORT = 3'd4;
    localparam logic [2:0] TL_STUCK = 3'd5;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  tail;
        logic [7:0]  nb;
        logic [15:0] lim;
        logic [7:0]  expd;
        logic [21:0] addr;
        logic [2:0]  res;
        logic [7:0]  reads;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, TL_DONE,  8'd3, 16'd20, 8'hA5, 22'h012340, 3'd1, 8'd4},  // R3 R4 word program ok
        '{2'd0, TL_DONE,  8'd0, 16'd20, 8'hA5, 22'h000010, 3'd1, 8'd2},  // R3 already done
        '{2'd2, TL_DONE,  8'd5, 16'd20, 8'h00, 22'h120000, 3'd1, 8'd6},  // R3 sector erase ok
        '{2'd3, TL_FAIL,  8'd2, 16'd20, 8'hFF, 22'h000555, 3'd2, 8'd5},  // R5 R7 chip erase fail
        '{2'd2, TL_LATE,  8'd4, 16'd20, 8'h00, 22'h0A0000, 3'd1, 8'd6},  // R5 flag with toggle stop
        '{2'd1, TL_ABORT, 8'd3, 16'd20, 8'h3C, 22'h2F0F0E, 3'd3, 8'd5},  // R6 R7 buffer abort
        '{2'd2, TL_ABORT, 8'd3, 16'd6,  8'h00, 22'h100000, 3'd4, 8'd7},  // R6 bit 1 ignored, R8
        '{2'd0, TL_HANG,  8'd0, 16'd4,  8'hA5, 22'h001234, 3'd4, 8'd5},  // R8 timeout
        '{2'd0, TL_STUCK, 8'd2, 16'd5,  8'h80, 22'h003000, 3'd4, 8'd6},  // R4 stable complement busy
        '{2'd3, TL_STUCK, 8'd2, 16'd5,  8'h80, 22'h003000, 3'd1, 8'd3},  // R4 erase ignores bit 7
        '{2'd0, TL_HANG,  8'd0, 16'd0,  8'hA5, 22'h000001, 3'd4, 8'd2},  // R8 zero budget
        '{2'd1, TL_FAIL,  8'd1, 16'd20, 8'h3C, 22'h3FFFFE, 3'd2, 8'd4}   // R5 R7 buffer fail
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        op_kind = '0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic [DATA_W-1:0] exp_data = '0;
    logic [CNT_W-1:0]  max_polls = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy;
    logic              done;
    logic [2:0]        result;

    int checks = 0;
    int fails  = 0;

    logic [2:0]        r_tail = TL_DONE;
    logic [7:0]        r_nb = '0;
    logic [7:0]        r_expd = '0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic              r_clear = 1'b0;
    int                nreads = 0;
    int                addr_err = 0;

    always #(CLK_P/2) clk = ~clk;

    fsp_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .poll_addr(poll_addr), .exp_data(exp_data), .max_polls(max_polls),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [7:0] status_byte(int idx, logic [2:0] tail,
                                               logic [7:0] nb, logic [7:0] e);
        logic [7:0] d;
        logic [7:0] nbm1;
        logic [7:0] ib;
        d = 8'h00;
        nbm1 = nb - 8'd1;
        ib = idx[7:0];
        if (idx < int'(nb)) begin
            d[7] = ~e[7];
            d[6] = ib[0];
        end else begin
            case (tail)
                TL_DONE: begin
                    d = e;
                    d[6] = (nb == 0) ? 1'b0 : nbm1[0];
                end
                TL_HANG:  begin d[7] = ~e[7]; d[6] = ib[0]; end
                TL_FAIL:  begin d[7] = ~e[7]; d[6] = ib[0]; d[5] = 1'b1; end
                TL_ABORT: begin d[7] = ~e[7]; d[6] = ib[0]; d[1] = 1'b1; end
                TL_LATE:  begin d[7] = ~e[7]; d[6] = nb[0]; d[5] = 1'b1; end
                default:  begin d[7] = ~e[7]; d[6] = (nb == 0) ? 1'b0 : nbm1[0]; end
            endcase
        end
        return d;
    endfunction

    // behavioural device read responder
    always @(posedge clk) begin
        if (r_clear) begin
            nreads   <= 0;
            addr_err <= 0;
            rd_ack   <= 1'b0;
        end else if (rd_req && !rd_ack) begin
            rd_ack  <= 1'b1;
            rd_data <= status_byte(nreads, r_tail, r_nb, r_expd);
            nreads  <= nreads + 1;
            if (rd_addr != r_addr) addr_err <= addr_err + 1;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic launch(logic [1:0] k, logic [2:0] tl, logic [7:0] nb,
                          logic [15:0] lim, logic [7:0] e, logic [21:0] a);
        @(negedge clk);
        r_tail = tl; r_nb = nb; r_expd = e; r_addr = a;
        r_clear = 1'b1;
        @(negedge clk);
        r_clear = 1'b0;
        op_kind = k; poll_addr = a; exp_data = e; max_polls = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done) check({tag, " done seen"}, 0, 1);
    endtask

    initial begin
        #(CLK_P * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 rd_req", int'(rd_req), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            launch(VECS[i].kind, VECS[i].tail, VECS[i].nb, VECS[i].lim,
                   VECS[i].expd, VECS[i].addr);
            wait_done($sformatf("vec%0d", i));
            check($sformatf("R3 R5 R6 R8 vec%0d result", i), int'(result), int'(VECS[i].res));
            check($sformatf("R7 R8 vec%0d read count", i), nreads, int'(VECS[i].reads));
            check($sformatf("R2 vec%0d address errors", i), addr_err, 0);
        end

        // R9: one-cycle pulse, sticky result
        launch(2'd2, TL_DONE, 8'd2, 16'd20, 8'h00, 22'h050000);
        wait_done("R9 run");
        @(negedge clk);
        check("R9 done pulse width", int'(done), 0);
        repeat (10) @(negedge clk);
        check("R9 sticky result", int'(result), 1);
        check("R9 busy after done", int'(busy), 0);

        // R10: start while busy is ignored
        launch(2'd0, TL_HANG, 8'd0, 16'd8, 8'hA5, 22'h0ABCDE);
        repeat (4) @(negedge clk);
        op_kind = 2'd3; poll_addr = 22'h111111; max_polls = 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 still busy", int'(busy), 1);
        wait_done("R10 run");
        check("R10 result", int'(result), 4);
        check("R10 read count", nreads, 9);
        check("R10 address errors", addr_err, 0);

        // R9: next start clears result
        launch(2'd0, TL_HANG, 8'd0, 16'd30, 8'hA5, 22'h000777);
        check("R9 cleared on start", int'(result), 0);
        wait_done("R9 clear run");
        check("R9 R8 cleared run result", int'(result), 4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule